// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer

This block moves control-register writes from a bus clock into an unrelated core clock. It serves a serial-interface peripheral. The writes are sorted into three groups, and each group has its own busy flag:

- **Reset group:** the software-reset bit.
- **Enable group:** the enable bit.
- **System-operation group:** the bus-state field, the address register and the data register share one flag.

Address and data writes need to cross only while the peripheral acts as a master. In any other mode the block leaves them alone.

A write that needs synchronizing is accepted only when its group is idle. The payload is latched into a bus-side holding register, and a toggle request crosses to the core clock. The core side returns a toggle acknowledge, and that acknowledge clears the busy flag. A write aimed at a group that is still busy is dropped and answered with a bus-error pulse.

The three groups run independently, so all of them may be in flight at once. Software can read the busy vector at any time to learn when a group is free again.

All bus-side ports are plain control pins: the block applies no valid/ready back-pressure. A rejected write is reported only through the error pulse, and the writer must retry it after the busy bit falls.

Top module: `regwr_xdom_sync`

## Requirements
- R1: While `rst_n` is low and right after it rises, `busy` is 3'b000, `bus_err` is 0 and every core-side strobe is 0.
- R2: Busy bit 0 belongs to the reset group, bit 1 to the enable group and bit 2 to the system-operation group. An accepted write sets its group's bit from the first bus-clock edge that samples it.
- R3: A synchronized write whose group bit is already 1 is dropped. It produces no core strobe and leaves the core value unchanged, and `bus_err` is 1 for the single bus cycle after that edge. Any other bus cycle leaves `bus_err` at 0.
- R4: Every accepted write produces exactly one single-cycle core strobe. The reset and enable groups carry `wr_data[0]`; the system-operation group carries all of `wr_data`.
- R5: The values of `wr_sel` mean: 0 software reset, 1 enable, 2 bus state, 3 address, 4 data. The values 5 to 7 select unsynchronized registers. Writes to those are ignored, with no busy bit, no error and no strobe.
- R6: With `master_mode` at 0, writes to select values 3 and 4 bypass the block. They cause no busy bit, no error and no strobe.
- R7: Bus-state, address and data writes share busy bit 2. A write to any one of them while another is in flight raises `bus_err`.
- R8: Each group is independent: a write to an idle group is accepted while other groups are busy.
- R9: A group's busy bit clears only after the core side has taken the value. The held payload stays stable while busy, and the next write to the group is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| core_clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_sel | input | 3 | Register select (see R5) |
| wr_data | input | DW | Write data |
| master_mode | input | 1 | Peripheral in master mode (bus domain) |
| busy | output | 3 | Per-group busy flags |
| bus_err | output | 1 | One-cycle pulse on a write rejected while busy |
| core_swrst_stb | output | 1 | Core strobe: software-reset write |
| core_swrst_val | output | 1 | Software-reset value |
| core_enable_stb | output | 1 | Core strobe: enable write |
| core_enable_val | output | 1 | Enable value |
| core_bstate_stb | output | 1 | Core strobe: bus-state write |
| core_addr_stb | output | 1 | Core strobe: address write |
| core_data_stb | output | 1 | Core strobe: data write |
| core_sysop_val | output | DW | Value of the last system-operation write |

## Verification
The bench targets the following corner cases:

- **Back-to-back writes to one group.** A design that failed to gate on busy would issue two strobes or overwrite the in-flight value.
- **A bus-state write landing on an in-flight address write.** A design with separate flags for these registers would accept the write and miss the shared-flag error.
- **Address and data writes with master mode off, and writes to select values 5 to 7.** A decoder that was too broad would set busy bit 2 or emit strobes.
- **Random mixes of all groups with random gaps.** These are compared strobe by strobe against a bench model. A design that cleared busy early, lost a toggle or dropped the payload would show count or value mismatches.

// File: rtl/xws_pkg.sv
package xws_pkg;
  localparam int NGRP = 3;
  localparam int G_RST = 0;
  localparam int G_EN  = 1;
  localparam int G_SYS = 2;

  localparam logic [2:0] SEL_SWRST  = 3'd0;
  localparam logic [2:0] SEL_ENABLE = 3'd1;
  localparam logic [2:0] SEL_BSTATE = 3'd2;
  localparam logic [2:0] SEL_ADDR   = 3'd3;
  localparam logic [2:0] SEL_DATA   = 3'd4;

  typedef enum logic [1:0] {
    K_BSTATE = 2'd0,
    K_ADDR   = 2'd1,
    K_DATA   = 2'd2
  } sys_kind_e;
endpackage

// File: rtl/xws_sync.sv
module xws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/xws_chan.sv
module xws_chan #(
  parameter int PW     = 1,
  parameter int STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          core_clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] pay,
  output logic          busy,
  output logic          err,
  output logic          core_stb,
  output logic [PW-1:0] core_pay
);
  logic          req_t, req_s, ack_t, ack_s;
  logic [PW-1:0] hold;
  logic          fire;

  // Group is busy while the request toggle has not come back as acknowledge.
  assign busy = req_t ^ ack_s;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t <= 1'b0;
      hold  <= '0;
      err   <= 1'b0;
    end else begin
      err <= load & busy;
      if (load && !busy) begin
        req_t <= ~req_t;
        hold  <= pay;
      end
    end
  end

  xws_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(core_clk), .rst_n(rst_n), .d(req_t), .q(req_s)
  );

  assign fire = req_s ^ ack_t;

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_t    <= 1'b0;
      core_stb <= 1'b0;
      core_pay <= '0;
    end else begin
      ack_t    <= req_s;
      core_stb <= fire;
      if (fire) core_pay <= hold;
    end
  end

  xws_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(ack_t), .q(ack_s)
  );

  p_busy_set_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (load && !busy) |=> busy);
  p_err_on_busy_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (load && busy) |=> err);
  p_no_spurious_err_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !load |=> !err);
  p_hold_stable_r9: assert property (@(posedge bus_clk) disable iff (!rst_n)
    busy |=> $stable(hold));
  p_single_pulse_r4: assert property (@(posedge core_clk) disable iff (!rst_n)
    core_stb |=> !core_stb);
endmodule

// File: rtl/regwr_xdom_sync.sv
module regwr_xdom_sync
  import xws_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          core_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          master_mode,
  output logic [2:0]    busy,
  output logic          bus_err,
  output logic          core_swrst_stb,
  output logic          core_swrst_val,
  output logic          core_enable_stb,
  output logic          core_enable_val,
  output logic          core_bstate_stb,
  output logic          core_addr_stb,
  output logic          core_data_stb,
  output logic [DW-1:0] core_sysop_val
);
  localparam int SPW = DW + 2;

  logic [NGRP-1:0] load, err_g;
  logic            is_ad;
  sys_kind_e       kind;
  logic [SPW-1:0]  sys_pay_in, sys_pay_out;
  logic            sys_stb;
  sys_kind_e       core_kind;

  assign is_ad = (wr_sel == SEL_ADDR) || (wr_sel == SEL_DATA);

  always_comb begin
    load        = '0;
    load[G_RST] = wr_en && (wr_sel == SEL_SWRST);
    load[G_EN]  = wr_en && (wr_sel == SEL_ENABLE);
    load[G_SYS] = wr_en && ((wr_sel == SEL_BSTATE) || (master_mode && is_ad));
    if (wr_sel == SEL_BSTATE)    kind = K_BSTATE;
    else if (wr_sel == SEL_ADDR) kind = K_ADDR;
    else                         kind = K_DATA;
  end

  assign sys_pay_in = {kind, wr_data};

  xws_chan #(.PW(1), .STAGES(SYNC_STAGES)) u_rst_chan (
    .bus_clk(bus_clk), .core_clk(core_clk), .rst_n(rst_n),
    .load(load[G_RST]), .pay(wr_data[0]), .busy(busy[G_RST]), .err(err_g[G_RST]),
    .core_stb(core_swrst_stb), .core_pay(core_swrst_val)
  );

  xws_chan #(.PW(1), .STAGES(SYNC_STAGES)) u_en_chan (
    .bus_clk(bus_clk), .core_clk(core_clk), .rst_n(rst_n),
    .load(load[G_EN]), .pay(wr_data[0]), .busy(busy[G_EN]), .err(err_g[G_EN]),
    .core_stb(core_enable_stb), .core_pay(core_enable_val)
  );

  xws_chan #(.PW(SPW), .STAGES(SYNC_STAGES)) u_sys_chan (
    .bus_clk(bus_clk), .core_clk(core_clk), .rst_n(rst_n),
    .load(load[G_SYS]), .pay(sys_pay_in), .busy(busy[G_SYS]), .err(err_g[G_SYS]),
    .core_stb(sys_stb), .core_pay(sys_pay_out)
  );

  assign bus_err        = |err_g;
  assign core_kind      = sys_kind_e'(sys_pay_out[SPW-1:DW]);
  assign core_sysop_val = sys_pay_out[DW-1:0];
  assign core_bstate_stb = sys_stb && (core_kind == K_BSTATE);
  assign core_addr_stb   = sys_stb && (core_kind == K_ADDR);
  assign core_data_stb   = sys_stb && (core_kind == K_DATA);

  p_unsync_ignored_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && (wr_sel > SEL_DATA)) |=> !bus_err);
  p_slave_bypass_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && !master_mode && is_ad) |=> !bus_err);
  p_shared_flag_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && busy[G_SYS] && (wr_sel == SEL_BSTATE)) |=> bus_err);
  p_reset_state_r1: assert property (@(posedge bus_clk)
    !rst_n |-> (busy == 3'b000 && !bus_err));
endmodule

// File: tb/regwr_xdom_sync_tb.sv
`timescale 1ns/1ps
module regwr_xdom_sync_tb;
  localparam int DW = 16;

  logic bus_clk = 0, core_clk = 0, rst_n = 0;
  logic wr_en = 0, master_mode = 0;
  logic [2:0] wr_sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic [2:0] busy;
  logic bus_err, core_swrst_stb, core_swrst_val, core_enable_stb, core_enable_val;
  logic core_bstate_stb, core_addr_stb, core_data_stb;
  logic [DW-1:0] core_sysop_val;

  always #2.5 bus_clk = ~bus_clk;
  always #3.5 core_clk = ~core_clk;

  regwr_xdom_sync #(.DW(DW)) u_dut (.*);

  int checks = 0, fails = 0, mchecks = 0, mfails = 0;
  int exp_cnt [5];
  int obs_cnt [5];
  logic exp_rst_v = 0, exp_en_v = 0;
  logic [DW-1:0] exp_sys_v = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Group index a write maps to, or -1 if not synchronized (R5, R6)
  function automatic int grp_of(input logic [2:0] sel, input logic mm);
    case (sel)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      3'd3, 3'd4: return mm ? 2 : -1;
      default: return -1;
    endcase
  endfunction

  // Core-side monitor: value check on each strobe (R4, R9)
  always @(negedge core_clk) begin
    if (rst_n) begin
      if (core_swrst_stb) begin
        obs_cnt[0]++; mchecks++;
        if (core_swrst_val !== exp_rst_v) begin
          mfails++; $display("FAIL R4 swrst value actual=%0h expected=%0h", core_swrst_val, exp_rst_v);
        end
      end
      if (core_enable_stb) begin
        obs_cnt[1]++; mchecks++;
        if (core_enable_val !== exp_en_v) begin
          mfails++; $display("FAIL R4 enable value actual=%0h expected=%0h", core_enable_val, exp_en_v);
        end
      end
      if (core_bstate_stb || core_addr_stb || core_data_stb) begin
        if (core_bstate_stb) obs_cnt[2]++;
        if (core_addr_stb)   obs_cnt[3]++;
        if (core_data_stb)   obs_cnt[4]++;
        mchecks++;
        if (core_sysop_val !== exp_sys_v) begin
          mfails++; $display("FAIL R4 sysop value actual=%0h expected=%0h", core_sysop_val, exp_sys_v);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    int g;
    bit perr;
    @(negedge bus_clk);
    g = grp_of(sel, master_mode);
    perr = (g >= 0) && busy[g];
    wr_en = 1; wr_sel = sel; wr_data = d;
    if (g >= 0 && !perr) begin
      exp_cnt[(g == 2) ? int'(sel) : g]++;
      if (g == 0) exp_rst_v = d[0];
      else if (g == 1) exp_en_v = d[0];
      else exp_sys_v = d;
    end
    @(negedge bus_clk);
    wr_en = 0;
    chk(bus_err === perr, "R3 bus_err", bus_err, perr);
    if (g >= 0 && !perr) chk(busy[g] === 1'b1, "R2 busy set", busy[g], 1);
    if (g < 0 && sel > 3'd4) chk(bus_err === 1'b0, "R5 unsync no err", bus_err, 0);
    if (g < 0 && sel <= 3'd4) chk(bus_err === 1'b0, "R6 slave bypass", bus_err, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && busy != 3'b000; i++) @(negedge bus_clk);
    repeat (12) @(negedge bus_clk);
    chk(busy === 3'b000, "R9 busy clears", busy, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + mchecks + 1, fails + mfails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge bus_clk);
    chk(busy === 3'b000 && bus_err === 1'b0, "R1 reset flags", {busy, bus_err}, 0);
    chk({core_swrst_stb, core_enable_stb, core_bstate_stb, core_addr_stb, core_data_stb} === 5'b0,
        "R1 reset strobes", 0, 0);
    rst_n = 1;
    repeat (2) @(negedge bus_clk);
    chk(busy === 3'b000, "R1 after release", busy, 0);

    // R3: back-to-back to the reset group, second one dropped
    wr(3'd0, 16'h1);
    wr(3'd0, 16'h0);
    // R8: enable group accepted while reset group busy
    wr(3'd1, 16'h1);
    drain();
    chk(core_swrst_val === 1'b1, "R3 dropped write no effect", core_swrst_val, 1);

    // R7: shared system-operation flag
    master_mode = 1;
    wr(3'd3, 16'hA5A5);
    wr(3'd2, 16'h0003);
    wr(3'd4, 16'h1234);
    drain();
    wr(3'd4, 16'h5678);   // R9: accepted once free
    drain();

    // R6: non-master address/data bypass
    master_mode = 0;
    wr(3'd3, 16'hBEEF);
    chk(busy[2] === 1'b0, "R6 no busy", busy[2], 0);
    wr(3'd4, 16'hCAFE);
    // R5: unsynchronized selects
    wr(3'd6, 16'hFFFF);
    chk(busy === 3'b000, "R5 no busy", busy, 0);
    drain();

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 == 0) master_mode = $urandom % 2;
      wr(3'($urandom % 8), 16'($urandom));
      repeat ($urandom % 7) @(negedge bus_clk);
    end
    drain();

    for (int k = 0; k < 5; k++)
      chk(obs_cnt[k] == exp_cnt[k], "R4 strobe count", obs_cnt[k], exp_cnt[k]);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule